// File: doc/BRIEF.md
# Register List Save/Restore Sequencer

This block moves a run of callee-saved general registers between the register file and a block of consecutive memory, one register per memory transaction. A command gives a start address, a 5-bit list field and a direction. The low four bits of the list field are a count. The count selects a prefix of a fixed, non-contiguous register order: 16 through 23, then 30. The top bit of the list field adds the return-address register (31) as a final transfer.

A save reads each register through the register-file read port and sends it out as a memory write. A restore issues memory reads and writes each returned value back into the register file. A parameter selects word transfers (4-byte stride, loaded words sign-extended) or doubleword transfers (8-byte stride, full width).

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the sequencer is idle, and a command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. The memory side is also valid/ready. Once `mem_valid` rises, the request (address, direction, write data, register index) stays unchanged until `mem_ready` is seen. For a read, the data must be on `mem_rdata` in that same ready cycle.

Top module: `regmulti_seq`

## Requirements
- R1: With a count (list bits [3:0]) from 1 to 9, exactly that many base registers are transferred, in the order 16,17,18,19,20,21,22,23,30, on `rf_idx`.
- R2: A count of 0 or of 10 to 15 transfers no base registers.
- R3: When list bit 4 is set, register 31 is transferred after all base registers, at the address just past the last base slot (at the start address if there are no base registers).
- R4: Slot k uses address start + k*4 in word mode (DW_MODE=0) and start + k*8 in doubleword mode (DW_MODE=1).
- R5: In word mode a read places mem_rdata[31:0] sign-extended to 64 bits on `rf_wdata`, and a write sends {32'b0, rf_rdata[31:0]} on `mem_wdata`. In doubleword mode both carry the full 64 bits.
- R6: While `mem_valid` is high and `mem_ready` is low, the request holds stable and the sequencer does not advance. `mem_write` is 1 for a save (cmd_store=1).
- R7: `done` is high for exactly one cycle. It comes the cycle after the last memory handshake, or the cycle after acceptance when nothing is selected.
- R8: `cmd_ready` is high only when idle. A `cmd_valid` seen while busy has no effect on the transfer in progress.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle, and low otherwise.
- R10: `rf_we` is high only in a read handshake cycle (mem_valid, mem_ready, not mem_write).
- R11: After reset: busy=0, done=0, mem_valid=0, rf_we=0, cmd_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command will be taken |
| cmd_addr | input | ADDR_W | Start address |
| cmd_list | input | 5 | [3:0] base count, [4] add register 31 |
| cmd_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rf_idx | output | 5 | Register index of the current slot |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | XLEN | Register write data |
| rf_rdata | input | XLEN | Register read data for rf_idx |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts / returns data |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with mem_ready |

## Verification
The first slot's request is visible one cycle after the accepting edge. Each later slot's request is visible one cycle after the previous handshake edge. `done` follows one cycle after the final handshake, and `busy` falls one cycle after that. Register write data and strobe are combinational in the handshake cycle itself. The bench therefore drives `mem_ready` just after each falling edge. A moment later it samples the combinational handshake outputs, before the rising edge that consumes them. The done and idle checks sit on the next one and two falling edges. A word-mode and a doubleword-mode instance run in lockstep on the same stimulus, so both strides and both data formats are checked on every slot.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int SLOT_W   = 4;
  localparam int BASE_MAX = 9;
  localparam logic [4:0] RA_REG = 5'd31;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} seq_state_e;

  // slot k of the base order: 16..23 then 30
  function automatic logic [4:0] base_reg(input logic [SLOT_W-1:0] k);
    return (k == SLOT_W'(8)) ? 5'd30 : (5'd16 + 5'(k));
  endfunction
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
(
  input  logic [4:0]        list,
  output logic [SLOT_W-1:0] nbase,
  output logic [SLOT_W-1:0] total
);
  logic [SLOT_W-1:0] cnt;
  logic              in_range;

  always_comb begin
    cnt      = SLOT_W'(list[3:0]);
    in_range = (cnt != '0) && (cnt <= SLOT_W'(BASE_MAX));
    nbase    = in_range ? cnt : '0;
    total    = nbase + SLOT_W'(list[4]);
  end
endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (adv)  addr <= addr + ADDR_W'(STEP);
  end
endmodule

// File: rtl/lsm_fmt.sv
module lsm_fmt #(
  parameter int XLEN    = 64,
  parameter bit DW_MODE = 1'b0
) (
  input  logic [XLEN-1:0] reg_in,
  input  logic [XLEN-1:0] mem_in,
  output logic [XLEN-1:0] mem_out,
  output logic [XLEN-1:0] reg_out
);
  generate
    if (DW_MODE || XLEN <= 32) begin : g_full
      assign mem_out = reg_in;
      assign reg_out = mem_in;
    end else begin : g_word
      logic unused_hi;
      assign unused_hi = ^{reg_in[XLEN-1:32], mem_in[XLEN-1:32]};
      assign mem_out   = {{(XLEN-32){1'b0}}, reg_in[31:0]};
      assign reg_out   = {{(XLEN-32){mem_in[31]}}, mem_in[31:0]};
    end
  endgenerate
endmodule

// File: rtl/regmulti_seq.sv
module regmulti_seq
  import lsm_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ADDR_W  = 32,
  parameter bit DW_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [4:0]        cmd_list,
  input  logic              cmd_store,
  output logic              busy,
  output logic              done,
  output logic [4:0]        rf_idx,
  output logic              rf_we,
  output logic [XLEN-1:0]   rf_wdata,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata
);
  localparam int STEP = DW_MODE ? 8 : 4;

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, nbase_q, total_q;
  logic [SLOT_W-1:0] nbase_d, total_d;
  logic              store_q;
  logic              accept, hs, last;

  lsm_decode u_dec (.list(cmd_list), .nbase(nbase_d), .total(total_d));

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign hs     = (state_q == ST_XFER) && mem_ready;
  assign last   = (slot_q == SLOT_W'(total_q - 1'b1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (total_d == '0) ? ST_FIN : ST_XFER;
      ST_XFER: if (hs && last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      nbase_q <= '0;
      total_q <= '0;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        slot_q  <= '0;
        nbase_q <= nbase_d;
        total_q <= total_d;
        store_q <= cmd_store;
      end else if (hs) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  lsm_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(cmd_addr),
    .adv(hs), .addr(mem_addr)
  );

  lsm_fmt #(.XLEN(XLEN), .DW_MODE(DW_MODE)) u_fmt (
    .reg_in(rf_rdata), .mem_in(mem_rdata), .mem_out(mem_wdata), .reg_out(rf_wdata)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign mem_valid = (state_q == ST_XFER);
  assign mem_write = mem_valid && store_q;
  assign rf_we     = hs && !store_q;

  always_comb begin
    if (state_q != ST_XFER)   rf_idx = 5'd0;
    else if (slot_q < nbase_q) rf_idx = base_reg(slot_q);
    else                       rf_idx = RA_REG;
  end

  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(rf_idx) && $stable(mem_write));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !rf_we && cmd_ready);
  a_r10_we_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_valid && mem_ready && !mem_write);
  a_r3_ra_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && rf_idx == RA_REG |=> !mem_valid && done);
endmodule

// File: tb/test_regmulti_seq.sv
module test_regmulti_seq;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int AW   = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_store = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [4:0]    cmd_list = '0;

  logic rdy_w, busy_w, done_w, we_w, mv_w, mw_w;
  logic rdy_d, busy_d, done_d, we_d, mv_d, mw_d;
  logic [4:0] idx_w, idx_d;
  logic [XLEN-1:0] rfw_w, rfr_w, mwd_w, mrd_w, rfw_d, rfr_d, mwd_d, mrd_d;
  logic [AW-1:0] ma_w, ma_d;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rv(input logic [4:0] i);
    return {32'hC0DE0000 | 32'(i), (i[0] ? 32'h80000000 : 32'h0) | (32'h12340000 + 32'(i))};
  endfunction
  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A5A5A, a * 32'h9E3779B1};
  endfunction
  function automatic logic [4:0] exp_reg(input int k, input int nb);
    if (k >= nb) return 5'd31;
    return (k == 8) ? 5'd30 : 5'(16 + k);
  endfunction

  assign rfr_w = rv(idx_w);
  assign rfr_d = rv(idx_d);
  assign mrd_w = pat(ma_w);
  assign mrd_d = pat(ma_d);

  regmulti_seq #(.XLEN(XLEN), .ADDR_W(AW), .DW_MODE(1'b0)) i_regmulti_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_w),
    .cmd_addr(cmd_addr), .cmd_list(cmd_list), .cmd_store(cmd_store),
    .busy(busy_w), .done(done_w), .rf_idx(idx_w), .rf_we(we_w), .rf_wdata(rfw_w),
    .rf_rdata(rfr_w), .mem_valid(mv_w), .mem_ready(mem_ready), .mem_write(mw_w),
    .mem_addr(ma_w), .mem_wdata(mwd_w), .mem_rdata(mrd_w));

  regmulti_seq #(.XLEN(XLEN), .ADDR_W(AW), .DW_MODE(1'b1)) i_regmulti_seq_dw (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_d),
    .cmd_addr(cmd_addr), .cmd_list(cmd_list), .cmd_store(cmd_store),
    .busy(busy_d), .done(done_d), .rf_idx(idx_d), .rf_we(we_d), .rf_wdata(rfw_d),
    .rf_rdata(rfr_d), .mem_valid(mv_d), .mem_ready(mem_ready), .mem_write(mw_d),
    .mem_addr(ma_d), .mem_wdata(mwd_d), .mem_rdata(mrd_d));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [31:0] base, input logic [4:0] lst, input bit st, input bit noisy);
    int cnt = int'(lst[3:0]);
    int nb  = (cnt >= 1 && cnt <= 9) ? cnt : 0;   // R1 / R2
    int tot = nb + int'(lst[4]);                  // R3
    int k = 0, guard = 0;
    logic [31:0] ea_w, ea_d;
    logic [63:0] rw;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = base; cmd_list = lst; cmd_store = st;
    #1 chk(rdy_w && rdy_d, "R8 idle ready", 64'(rdy_w), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (k < tot && guard < 200) begin
      guard++;
      mem_ready = ($urandom % 3) != 0;
      if (noisy) begin
        cmd_valid = ($urandom % 2) != 0;
        cmd_list  = 5'($urandom);
        cmd_addr  = $urandom;
        cmd_store = ~st;
      end
      #1;
      chk(busy_w && busy_d && !done_w, "R9 busy in run", 64'(busy_w), 64'd1);
      chk(mv_w && mv_d, "R6 request held", 64'(mv_w), 64'd1);
      if (!mem_ready) chk(!we_w && !we_d, "R10 no we while waiting", 64'(we_w), 64'd0);
      if (mv_w && mem_ready) begin
        ea_w = base + 32'(k * 4);
        ea_d = base + 32'(k * 8);
        chk(ma_w == ea_w, "R4 word stride", 64'(ma_w), 64'(ea_w));
        chk(ma_d == ea_d, "R4 dword stride", 64'(ma_d), 64'(ea_d));
        chk(idx_w == exp_reg(k, nb) && idx_d == idx_w, k >= nb ? "R3 ra slot" : "R1 base order",
            64'(idx_w), 64'(exp_reg(k, nb)));
        chk(mw_w == st && mw_d == st, "R6 direction", 64'(mw_w), 64'(st));
        if (st) begin
          rw = {32'h0, rv(exp_reg(k, nb))};
          rw = {32'h0, rw[31:0]};
          chk(mwd_w == rw, "R5 word store data", mwd_w, rw);
          chk(mwd_d == rv(exp_reg(k, nb)), "R5 dword store data", mwd_d, rv(exp_reg(k, nb)));
          chk(!we_w && !we_d, "R10 no we on store", 64'(we_w), 64'd0);
        end else begin
          rw = pat(ea_w);
          rw = {{32{rw[31]}}, rw[31:0]};
          chk(we_w && we_d, "R10 we on load", 64'(we_w), 64'd1);
          chk(rfw_w == rw, "R5 word load sext", rfw_w, rw);
          chk(rfw_d == pat(ea_d), "R5 dword load", rfw_d, pat(ea_d));
        end
        k++;
      end
      @(negedge clk);
    end
    chk(k == tot, "R1 slot count", 64'(k), 64'(tot));
    cmd_valid = 1'b0;
    mem_ready = 1'b1;
    #1;
    chk(done_w && done_d && busy_w, tot == 0 ? "R7 done at once (R2)" : "R7 done after last",
        64'(done_w), 64'd1);
    chk(!mv_w && !mv_d, "R2 no extra request", 64'(mv_w), 64'd0);
    @(negedge clk);
    mem_ready = 1'b0;
    #1;
    chk(!done_w && !busy_w && rdy_w && !done_d, "R7 single pulse / R9 busy drop",
        {done_w, busy_w}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 chk(!busy_w && !done_w && !mv_w && !we_w && rdy_w, "R11 reset state",
           {busy_w, done_w, mv_w, we_w, rdy_w}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!busy_w && !done_w && !mv_w && rdy_w, "R11 idle after reset", 64'(busy_w), 64'd0);
    // directed corner cases
    run_cmd(32'h1000, 5'd9,  1'b1, 1'b0);  // R1 full base list
    run_cmd(32'h2000, 5'd25, 1'b0, 1'b0);  // R3 all nine plus ra
    run_cmd(32'h3000, 5'd0,  1'b1, 1'b0);  // R2 empty
    run_cmd(32'h3100, 5'd10, 1'b0, 1'b0);  // R2 out of range
    run_cmd(32'h3200, 5'd15, 1'b1, 1'b0);  // R2 out of range
    run_cmd(32'h4000, 5'd16, 1'b0, 1'b0);  // R3 ra alone at start address
    run_cmd(32'h5000, 5'd31, 1'b1, 1'b0);  // R3 out-of-range count plus ra
    run_cmd(32'h6000, 5'd1,  1'b0, 1'b1);  // R8 noise while busy
    for (int n = 0; n < 60; n++)
      run_cmd($urandom & 32'hFFFF_FFF8, 5'($urandom), 1'($urandom), (n % 3) == 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule